// File: doc/BRIEF.md
# Strobed Serial Command Decoder

This block is the host-facing front end of a display and keypad panel controller. A host drives three wires: a strobe that frames each transfer, a shift clock, and a data line. Bits are taken most significant first on each rising shift-clock edge. In every strobe window the first complete byte is a command. The command class sits in its top two bits and selects one of four settings: panel setup, data mode, address pointer or status. Every later byte in the same window is a data byte, and the block handles it according to the data mode in force.

In a write mode, a data byte goes out on a single-cycle write port to one of three RAMs: character display, pictograph or user glyph. The byte can also update a four-bit LED latch held inside the block. The address pointer can advance after each RAM write or stay fixed. A pointer above the limit of the current target blocks writes and does not move. In key-read mode, the block returns four key bytes on the data line, driving them on falling shift-clock edges through an open-drain style enable.

All three serial inputs are oversampled in the system clock domain. The reset is asynchronous, active low, and released synchronously inside the block.

Top module: `strobed_cmd_decoder`

## Requirements
- R1: After reset, `panel_cfg`, `status_cfg` and `led_latch` are zero, `ser_dout_oe` is low, and no write is issued.
- R2: Bits are sampled MSB first on rising `ser_clk` while `ser_stb` is high. The first byte of a window is a command classed by bits [7:6]. Class 00 loads `panel_cfg` from bits [2:0]. Class 11 loads `status_cfg` from bits [5:0].
- R3: Class 01 sets the data mode from bits [2:0], and each mode selects how later data bytes are used. 000 writes to `wr_tgt`=0 (display). 001 writes to `wr_tgt`=1 (pictograph). 010 writes to `wr_tgt`=2 (glyph). 011 loads the LED latch. 100 reads keys. Codes 101 to 111 cause no write and no latch change.
- R4: Class 01 bit 3 equal to 0 advances the pointer by one after each display or pictograph write. Bit 3 equal to 1 keeps the pointer fixed.
- R5: Class 10 loads the pointer from bits [4:0]. If the pointer exceeds the limit of the current mode, the byte is dropped and the pointer holds until a valid address is loaded. The limits are 0x18 for display, 0x07 for pictograph and 0x0F for glyph.
- R6: A glyph write carries the pointer as the glyph code, the row from data bits [7:5] on `wr_row`, and data bits [4:0] on `wr_data` with its upper bits zero. A row of 7 is dropped, and the pointer never advances.
- R7: An LED latch write takes data bits [3:0] and ignores bits [7:4].
- R8: If the strobe drops during a byte, the partial bits are discarded and the bit count restarts. Bytes completed earlier in that window keep their effect.
- R9: In key-read mode, each data byte slot returns the next `key_data` byte, bits [31:24] first, MSB first. Each bit changes on falling `ser_clk`. A 0 bit raises `ser_dout_oe` and a 1 bit releases it. After four bytes the line stays released, and no write is issued.
- R10: `ser_dout_oe` is low whenever the strobe is low and in every write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (idles high) |
| ser_stb | input | 1 | Transfer strobe, active high |
| ser_din | input | 1 | Serial data in |
| ser_dout_oe | output | 1 | Pull data line low when 1 |
| key_data | input | 32 | Key matrix state, four bytes |
| panel_cfg | output | 3 | Panel setup field |
| status_cfg | output | 6 | Status field |
| led_latch | output | 4 | LED latch |
| wr_en | output | 1 | Single-cycle RAM write strobe |
| wr_tgt | output | 2 | Write target: 0 display, 1 pictograph, 2 glyph |
| wr_addr | output | 5 | RAM address or glyph code |
| wr_row | output | 3 | Glyph row |
| wr_data | output | 8 | Write data |

## Verification
A byte's effect (a write pulse or a register update) appears four system clocks after its eighth rising shift-clock edge. Two of those clocks are synchronizer stages, one is edge detection and one is the decode register. A read bit reaches `ser_dout_oe` three clocks after the falling edge. The bench holds each shift-clock phase for ten system clocks. It samples registers and the read line only at the end of a phase, so every result is already settled. It records write pulses on the falling system clock, and then compares the full list of writes with arithmetically predicted addresses, rows and data.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_PANEL  = 2'b00,
    CLS_MODE   = 2'b01,
    CLS_ADDR   = 2'b10,
    CLS_STATUS = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    MD_DISP  = 3'b000,
    MD_PICT  = 3'b001,
    MD_GLYPH = 3'b010,
    MD_LED   = 3'b011,
    MD_KEYRD = 3'b100,
    MD_RSV5  = 3'b101,
    MD_RSV6  = 3'b110,
    MD_RSV7  = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    TGT_DISP  = 2'd0,
    TGT_PICT  = 2'd1,
    TGT_GLYPH = 2'd2
  } tgt_e;
endpackage

// File: rtl/scd_sync.sv
// Multi-stage input synchronizer; lane 0 also gets edge pulses.
module scd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic         rise0_o,
  output logic         fall0_o
);
  logic [W-1:0] stg_q [STAGES];
  logic         prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= 1'b0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1][0];
    end
  end

  assign lvl_o   = stg_q[STAGES-1];
  assign rise0_o = stg_q[STAGES-1][0] & ~prev_q;
  assign fall0_o = ~stg_q[STAGES-1][0] & prev_q;
endmodule

// File: rtl/scd_shifter.sv
// Byte assembly with window-relative command marking and abort.
module scd_shifter
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              sck_rise,
  input  logic              din,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_cmd_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              cmd_q, cmd_d;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    vld_d   = 1'b0;
    byte_d  = byte_q;
    cmd_d   = cmd_q;
    if (!stb) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (sck_rise) begin
      sh_d  = {sh_q[BYTE_W-3:0], din};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        vld_d   = 1'b1;
        byte_d  = {sh_q, din};
        cmd_d   = first_q;
        first_d = 1'b0;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      vld_q   <= 1'b0;
      byte_q  <= '0;
      cmd_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      vld_q   <= vld_d;
      byte_q  <= byte_d;
      cmd_q   <= cmd_d;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign is_cmd_o   = cmd_q;
endmodule

// File: rtl/scd_ctrl.sv
// Command decode, mode registers, address pointer and write port.
module scd_ctrl
  import scd_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DISP_LAST  = 24,
  parameter int PICT_LAST  = 7,
  parameter int GLYPH_LAST = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              is_cmd,
  output logic [2:0]        panel_o,
  output logic [5:0]        status_o,
  output logic [3:0]        led_o,
  output logic              wr_en_o,
  output logic [1:0]        wr_tgt_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [2:0]        wr_row_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_load_o
);
  localparam logic [2:0] ROW_BAD = 3'd7;

  logic [2:0]        panel_q, panel_d;
  logic [5:0]        stat_q, stat_d;
  logic [3:0]        led_q, led_d;
  mode_e             mode_q, mode_d;
  logic              fix_q, fix_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              wen_q, wen_d;
  logic [1:0]        tgt_q, tgt_d;
  logic [ADDR_W-1:0] wadr_q, wadr_d;
  logic [2:0]        row_q, row_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              rdl_q, rdl_d;
  logic [ADDR_W-1:0] limit;
  logic              ptr_ok;

  always_comb begin
    case (mode_q)
      MD_DISP:  limit = ADDR_W'(DISP_LAST);
      MD_PICT:  limit = ADDR_W'(PICT_LAST);
      MD_GLYPH: limit = ADDR_W'(GLYPH_LAST);
      default:  limit = '0;
    endcase
    ptr_ok = (ptr_q <= limit);
  end

  always_comb begin
    panel_d = panel_q;
    stat_d  = stat_q;
    led_d   = led_q;
    mode_d  = mode_q;
    fix_d   = fix_q;
    ptr_d   = ptr_q;
    wen_d   = 1'b0;
    tgt_d   = tgt_q;
    wadr_d  = wadr_q;
    row_d   = row_q;
    wdat_d  = wdat_q;
    rdl_d   = 1'b0;
    if (byte_vld && is_cmd) begin
      case (cls_e'(byte_i[7:6]))
        CLS_PANEL:  panel_d = byte_i[2:0];
        CLS_MODE: begin
          mode_d = mode_e'(byte_i[2:0]);
          fix_d  = byte_i[3];
          rdl_d  = (mode_e'(byte_i[2:0]) == MD_KEYRD);
        end
        CLS_ADDR:   ptr_d  = byte_i[ADDR_W-1:0];
        CLS_STATUS: stat_d = byte_i[5:0];
        default: ;
      endcase
    end else if (byte_vld) begin
      case (mode_q)
        MD_DISP, MD_PICT: begin
          if (ptr_ok) begin
            wen_d  = 1'b1;
            tgt_d  = (mode_q == MD_DISP) ? TGT_DISP : TGT_PICT;
            wadr_d = ptr_q;
            row_d  = '0;
            wdat_d = byte_i;
            if (!fix_q) ptr_d = ptr_q + 1'b1;
          end
        end
        MD_GLYPH: begin
          if (ptr_ok && byte_i[7:5] != ROW_BAD) begin
            wen_d  = 1'b1;
            tgt_d  = TGT_GLYPH;
            wadr_d = ptr_q;
            row_d  = byte_i[7:5];
            wdat_d = {3'b000, byte_i[4:0]};
          end
        end
        MD_LED:   led_d = byte_i[3:0];
        MD_KEYRD: rdl_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      panel_q <= '0;
      stat_q  <= '0;
      led_q   <= '0;
      mode_q  <= MD_DISP;
      fix_q   <= 1'b0;
      ptr_q   <= '0;
      wen_q   <= 1'b0;
      tgt_q   <= '0;
      wadr_q  <= '0;
      row_q   <= '0;
      wdat_q  <= '0;
      rdl_q   <= 1'b0;
    end else begin
      panel_q <= panel_d;
      stat_q  <= stat_d;
      led_q   <= led_d;
      mode_q  <= mode_d;
      fix_q   <= fix_d;
      ptr_q   <= ptr_d;
      wen_q   <= wen_d;
      rdl_q   <= rdl_d;
      if (wen_d) begin
        tgt_q  <= tgt_d;
        wadr_q <= wadr_d;
        row_q  <= row_d;
        wdat_q <= wdat_d;
      end
    end
  end

  assign panel_o   = panel_q;
  assign status_o  = stat_q;
  assign led_o     = led_q;
  assign wr_en_o   = wen_q;
  assign wr_tgt_o  = tgt_q;
  assign wr_addr_o = wadr_q;
  assign wr_row_o  = row_q;
  assign wr_data_o = wdat_q;
  assign rd_load_o = rdl_q;
endmodule

// File: rtl/scd_readout.sv
// Key byte serializer driving an open-drain style enable.
module scd_readout
  import scd_pkg::*;
#(
  parameter int KEY_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        stb,
  input  logic                        sck_fall,
  input  logic                        rd_load,
  input  logic [KEY_BYTES*BYTE_W-1:0] key_i,
  output logic                        oe_o
);
  localparam int IDX_W = $clog2(KEY_BYTES + 1);

  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              act_q, act_d;
  logic              bit_q, bit_d;

  always_comb begin
    tx_d  = tx_q;
    idx_d = idx_q;
    act_d = act_q;
    bit_d = bit_q;
    if (!stb) begin
      tx_d  = '1;
      idx_d = '0;
      act_d = 1'b0;
      bit_d = 1'b1;
    end else begin
      if (sck_fall && act_q) begin
        bit_d = tx_q[BYTE_W-1];
        tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
      end
      if (rd_load) begin
        act_d = 1'b1;
        tx_d  = '1;
        for (int k = 0; k < KEY_BYTES; k++) begin
          if (idx_q == IDX_W'(k)) tx_d = key_i[BYTE_W*(KEY_BYTES-1-k) +: BYTE_W];
        end
        if (idx_q != IDX_W'(KEY_BYTES)) idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '1;
      idx_q <= '0;
      act_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      tx_q  <= tx_d;
      idx_q <= idx_d;
      act_q <= act_d;
      bit_q <= bit_d;
    end
  end

  assign oe_o = act_q & ~bit_q;
endmodule

// File: rtl/strobed_cmd_decoder.sv
module strobed_cmd_decoder
  import scd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int KEY_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DISP_LAST   = 24,
  parameter int PICT_LAST   = 7,
  parameter int GLYPH_LAST  = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_stb,
  input  logic                        ser_din,
  output logic                        ser_dout_oe,
  input  logic [KEY_BYTES*BYTE_W-1:0] key_data,
  output logic [2:0]                  panel_cfg,
  output logic [5:0]                  status_cfg,
  output logic [3:0]                  led_latch,
  output logic                        wr_en,
  output logic [1:0]                  wr_tgt,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [2:0]                  wr_row,
  output logic [BYTE_W-1:0]           wr_data
);
  logic [1:0]        rst_q;
  logic              rst_s_n;
  logic [2:0]        pins_lvl;
  logic              sck_rise, sck_fall;
  logic              stb_lvl, din_lvl;
  logic              byte_vld, is_cmd, rd_load;
  logic [BYTE_W-1:0] byte_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  scd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n),
    .async_i({ser_din, ser_stb, ser_clk}),
    .lvl_o(pins_lvl), .rise0_o(sck_rise), .fall0_o(sck_fall)
  );
  assign stb_lvl = pins_lvl[1];
  assign din_lvl = pins_lvl[2];

  scd_shifter u_shift (
    .clk(clk), .rst_n(rst_s_n), .stb(stb_lvl), .sck_rise(sck_rise),
    .din(din_lvl), .byte_vld_o(byte_vld), .byte_o(byte_w), .is_cmd_o(is_cmd)
  );

  scd_ctrl #(
    .ADDR_W(ADDR_W), .DISP_LAST(DISP_LAST),
    .PICT_LAST(PICT_LAST), .GLYPH_LAST(GLYPH_LAST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .byte_vld(byte_vld), .byte_i(byte_w),
    .is_cmd(is_cmd), .panel_o(panel_cfg), .status_o(status_cfg),
    .led_o(led_latch), .wr_en_o(wr_en), .wr_tgt_o(wr_tgt),
    .wr_addr_o(wr_addr), .wr_row_o(wr_row), .wr_data_o(wr_data),
    .rd_load_o(rd_load)
  );

  scd_readout #(.KEY_BYTES(KEY_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_s_n), .stb(stb_lvl), .sck_fall(sck_fall),
    .rd_load(rd_load), .key_i(key_data), .oe_o(ser_dout_oe)
  );
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int ADDR_W     = 5,
  parameter int DISP_LAST  = 24,
  parameter int PICT_LAST  = 7,
  parameter int GLYPH_LAST = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_lvl,
  input logic              ser_dout_oe,
  input logic              wr_en,
  input logic [1:0]        wr_tgt,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [2:0]        wr_row,
  input logic [7:0]        wr_data
);
  // R10
  line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_lvl |=> !ser_dout_oe);

  // R3
  tgt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_tgt != 2'd3));

  // R5
  disp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd0) |-> (int'(wr_addr) <= DISP_LAST));

  // R5
  pict_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd1) |-> (int'(wr_addr) <= PICT_LAST));

  // R6
  glyph_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd2) |->
      (wr_row != 3'd7 && wr_data[7:5] == 3'd0 && int'(wr_addr) <= GLYPH_LAST));

  // R9
  no_write_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_dout_oe |-> !wr_en);

  // R8
  write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(stb_lvl));
endmodule

bind strobed_cmd_decoder scd_checker #(
  .ADDR_W(ADDR_W), .DISP_LAST(DISP_LAST),
  .PICT_LAST(PICT_LAST), .GLYPH_LAST(GLYPH_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_lvl(stb_lvl), .ser_dout_oe(ser_dout_oe),
  .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_row(wr_row),
  .wr_data(wr_data)
);

// File: tb/sim_strobed_cmd_decoder.sv
`timescale 1ns/1ps
module sim_strobed_cmd_decoder;
  localparam int HP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b1;
  logic        ser_stb = 1'b0;
  logic        ser_din = 1'b1;
  logic [31:0] key_data = 32'h5AC3_0F81;
  logic        ser_dout_oe;
  logic [2:0]  panel_cfg;
  logic [5:0]  status_cfg;
  logic [3:0]  led_latch;
  logic        wr_en;
  logic [1:0]  wr_tgt;
  logic [4:0]  wr_addr;
  logic [2:0]  wr_row;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_bad = 0;
  int wr_total = 0;
  int base = 0;
  logic [17:0] wlog [64];

  always #4 clk = ~clk;

  strobed_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb(ser_stb),
    .ser_din(ser_din), .ser_dout_oe(ser_dout_oe), .key_data(key_data),
    .panel_cfg(panel_cfg), .status_cfg(status_cfg), .led_latch(led_latch),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_row(wr_row),
    .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      wlog[wr_total % 64] <= {wr_tgt, wr_addr, wr_row, wr_data};
      wr_total <= wr_total + 1;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int k, input int tgt,
                        input int adr, input int row, input int dat);
    chk(req, int'(wlog[(base + k) % 64]), (tgt << 16) | (adr << 11) | (row << 8) | dat);
  endtask

  task automatic send_bit(input logic b);
    ser_clk = 1'b0;
    ser_din = b;
    wait_clk(HP);
    ser_clk = 1'b1;
    wait_clk(HP);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic stb_on();
    ser_stb = 1'b1;
    wait_clk(HP);
  endtask

  task automatic stb_off();
    ser_stb = 1'b0;
    ser_din = 1'b1;
    wait_clk(HP);
  endtask

  task automatic xfer(input logic [7:0] b);
    stb_on();
    send_byte(b);
    stb_off();
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      ser_clk = 1'b0;
      ser_din = 1'b1;
      wait_clk(HP);
      v[i] = ~ser_dout_oe;
      ser_clk = 1'b1;
      wait_clk(HP);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rb;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    chk("R1 panel", int'(panel_cfg), 0);
    chk("R1 status", int'(status_cfg), 0);
    chk("R1 led", int'(led_latch), 0);
    chk("R1 oe", int'(ser_dout_oe), 0);
    chk("R1 writes", wr_total, 0);

    // R2 command classes, MSB first
    xfer(8'h06);
    chk("R2 panel 110", int'(panel_cfg), 6);
    xfer(8'h03);
    chk("R2 panel 011", int'(panel_cfg), 3);
    xfer(8'hED);
    chk("R2 status", int'(status_cfg), 6'h2D);
    chk("R2 panel kept", int'(panel_cfg), 3);

    // R3 R4 display writes with increment; R10 line idle in write mode
    base = wr_total;
    xfer(8'h83);
    stb_on(); send_byte(8'h40); send_byte(8'h11); send_byte(8'h22);
    chk("R10 oe in write mode", int'(ser_dout_oe), 0);
    send_byte(8'h33); stb_off();
    chk("R4 inc count", wr_total - base, 3);
    chk_wr("R3 disp w0", 0, 0, 3, 0, 8'h11);
    chk_wr("R4 disp w1", 1, 0, 4, 0, 8'h22);
    chk_wr("R4 disp w2", 2, 0, 5, 0, 8'h33);

    // R4 fixed address
    base = wr_total;
    xfer(8'h85);
    stb_on(); send_byte(8'h48); send_byte(8'h55); send_byte(8'h66); stb_off();
    chk("R4 fixed count", wr_total - base, 2);
    chk_wr("R4 fixed w0", 0, 0, 5, 0, 8'h55);
    chk_wr("R4 fixed w1", 1, 0, 5, 0, 8'h66);

    // R3 R5 pictograph with overrun
    base = wr_total;
    xfer(8'h86);
    stb_on(); send_byte(8'h41); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3); stb_off();
    chk("R5 pict overrun count", wr_total - base, 2);
    chk_wr("R3 pict w0", 0, 1, 6, 0, 8'hA1);
    chk_wr("R5 pict w1", 1, 1, 7, 0, 8'hA2);
    stb_on(); send_byte(8'h41); send_byte(8'hA4); stb_off();
    chk("R5 frozen pointer", wr_total - base, 2);
    xfer(8'h82);
    stb_on(); send_byte(8'h41); send_byte(8'hA5); stb_off();
    chk("R5 recovered count", wr_total - base, 3);
    chk_wr("R5 recovered w", 2, 1, 2, 0, 8'hA5);

    // R5 display limit 0x18 and 0x19
    base = wr_total;
    xfer(8'h98);
    stb_on(); send_byte(8'h40); send_byte(8'h01); send_byte(8'h02); stb_off();
    xfer(8'h99);
    stb_on(); send_byte(8'h40); send_byte(8'h03); stb_off();
    chk("R5 disp limit count", wr_total - base, 1);
    chk_wr("R5 disp last", 0, 0, 24, 0, 8'h01);

    // R6 glyph rows
    base = wr_total;
    xfer(8'h8F);
    stb_on(); send_byte(8'h42); send_byte(8'h56); send_byte(8'hE1); send_byte(8'h1F); stb_off();
    xfer(8'h90);
    stb_on(); send_byte(8'h42); send_byte(8'h20); stb_off();
    chk("R6 glyph count", wr_total - base, 2);
    chk_wr("R6 glyph row2", 0, 2, 15, 2, 8'h16);
    chk_wr("R6 glyph row0", 1, 2, 15, 0, 8'h1F);

    // R7 LED latch
    base = wr_total;
    stb_on(); send_byte(8'h43); send_byte(8'hF5); stb_off();
    chk("R7 led low nibble", int'(led_latch), 5);
    stb_on(); send_byte(8'h43); send_byte(8'hAA); stb_off();
    chk("R7 led second", int'(led_latch), 10);
    chk("R7 no ram write", wr_total - base, 0);

    // R3 reserved mode
    xfer(8'h80);
    stb_on(); send_byte(8'h45); send_byte(8'h33); stb_off();
    chk("R3 reserved no write", wr_total - base, 0);
    chk("R3 reserved led kept", int'(led_latch), 10);

    // R8 abort mid-byte
    xfer(8'h06);
    stb_on(); for (int i = 0; i < 5; i++) send_bit(1'b1); stb_off();
    chk("R8 partial discarded", int'(panel_cfg), 6);
    xfer(8'h01);
    chk("R8 counter restarted", int'(panel_cfg), 1);
    base = wr_total;
    xfer(8'h80);
    stb_on(); send_byte(8'h40); send_byte(8'h77);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    stb_off();
    stb_on(); send_byte(8'h40); send_byte(8'h12); stb_off();
    chk("R8 write count", wr_total - base, 2);
    chk_wr("R8 kept byte", 0, 0, 0, 0, 8'h77);
    chk_wr("R8 next addr", 1, 0, 1, 0, 8'h12);

    // R9 key read
    base = wr_total;
    stb_on(); send_byte(8'h44);
    read_byte(rb); chk("R9 key byte0", int'(rb), 8'h5A);
    read_byte(rb); chk("R9 key byte1", int'(rb), 8'hC3);
    read_byte(rb); chk("R9 key byte2", int'(rb), 8'h0F);
    read_byte(rb); chk("R9 key byte3", int'(rb), 8'h81);
    read_byte(rb); chk("R9 released after four", int'(rb), 8'hFF);
    stb_off();
    chk("R9 no write", wr_total - base, 0);
    chk("R10 oe after strobe", int'(ser_dout_oe), 0);

    summary();
    $finish;
  end
endmodule